// File: doc/BRIEF.md
# Variable-Length Instruction Window

This block is a per-thread staging buffer between instruction fetch and a dual-issue front end. Fetch delivers 64-bit words of raw code. The window keeps them as an ordered queue of 16-bit parcels. Each instruction is one or two parcels long and may begin on any parcel, so an instruction can straddle two fetch words.

Every cycle the block offers the first two complete instructions at the head of the queue as two issue slots. The issue logic reports how many of them it takes, and the window retires exactly those parcels.

For the fetch controller the window reports four things:
- how many parcels it holds;
- whether it can accept another word;
- whether a word could be fetched once this cycle's retirement is counted;
- whether any complete instruction it holds is a control-flow instruction.

A flush input empties it when the thread's control flow is redirected.

Top module: `instr_window`

## Requirements
- R1: After a synchronous active-low reset, `level_o` is 0, both slot valids and `full_o` and `has_branch_o` are 0, and `refill_req_o` is 1.
- R2: The length of the head instruction comes from bit 0 of its first parcel: 1 selects a 32-bit instruction, 0 a 16-bit one. `slot0_instr_o` is {second parcel, first parcel} for a 32-bit instruction and the first parcel zero-extended for a 16-bit one. `slot0_long_o` is that length bit.
- R3: A 32-bit instruction is offered only when both of its parcels are in the window. A lone first parcel leaves the slot invalid.
- R4: Slot 1 holds the instruction that starts right after the slot 0 instruction, with the same length and format rules. It is valid only when slot 0 is valid and all of its own parcels are present.
- R5: `take_i` (0, 1 or 2; the value 3 acts as 2) removes that many instructions from the head at the clock edge. The count is clamped to the number of valid slots, and the level drops by the parcels those instructions occupy.
- R6: A fetch word that is offered and accepted appends four parcels at the tail. Bits [15:0] come first in program order and bits [63:48] last, and the level rises by 4 (minus any parcels retired in the same cycle).
- R7: `full_o` is 1 exactly when fewer than four of the twelve parcel slots are free. A word offered while `full_o` is 1 is dropped, and the level never exceeds 12.
- R8: `refill_req_o` is 1 when at least four slots would be free after this cycle's retirement, with any word accepted this cycle left out of the count. It is therefore 1 whenever `full_o` is 0.
- R9: `flush_i` empties the window at the next edge. It overrides any fetch word and any take in the same cycle.
- R10: `has_branch_o` is 1 when some complete instruction, found by walking lengths from the head, has a first parcel whose low byte is 0x3C, 0x5E, 0x1D or 0x6D. An incomplete trailing 32-bit instruction does not count.
- R11: Parcel order is preserved when storage wraps around, over any mix of fetch, take and flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Empty the window |
| fetch_valid_i | input | 1 | A fetch word is offered |
| fetch_word_i | input | 64 | Fetched code, earliest parcel in bits [15:0] |
| take_i | input | 2 | Number of head instructions consumed this cycle |
| slot0_valid_o | output | 1 | Head instruction complete |
| slot0_long_o | output | 1 | Head instruction is 32-bit |
| slot0_instr_o | output | 32 | Head instruction |
| slot1_valid_o | output | 1 | Second instruction complete |
| slot1_long_o | output | 1 | Second instruction is 32-bit |
| slot1_instr_o | output | 32 | Second instruction |
| level_o | output | 4 | Parcels held |
| full_o | output | 1 | No room for a further fetch word |
| refill_req_o | output | 1 | Room for a word once this cycle's retirement is counted |
| has_branch_o | output | 1 | A complete control-flow instruction is held |

## Verification
The case that needs care is a fetch word being appended in the same cycle that one or two instructions are retired from the head. The new level, the tail position and the next head all depend on both at once, and a 32-bit instruction left waiting for its second parcel may become complete in that cycle. Random stimulus keeps the window partly filled, with a fetch word offered in most cycles and random take counts, so the two events coincide often. Directed steps add the straddling instruction, the full and flush edge cases, and a trailing incomplete control-flow instruction. Every cycle the bench compares all outputs against a parcel-queue model, and it compares the level again after each combined edge.

// File: rtl/iw_pkg.sv
// Package: shared parcel type and the control-flow opcode match table.
// Assumes the instruction length bit is bit 0 of the first parcel.
package iw_pkg;
    localparam int PARCEL_W = 16;
    typedef logic [PARCEL_W-1:0] parcel_t;

    localparam int N_CTRL = 4;
    localparam parcel_t CTRL_VAL  [N_CTRL] = '{16'h003C, 16'h005E, 16'h001D, 16'h006D};
    localparam parcel_t CTRL_MASK [N_CTRL] = '{16'h00FF, 16'h00FF, 16'h00FF, 16'h00FF};

    // Returns 1 when a first parcel matches any control-flow table entry.
    function automatic logic is_ctrl(parcel_t p);
        logic m;
        m = 1'b0;
        for (int k = 0; k < N_CTRL; k++) begin
            if (((p ^ CTRL_VAL[k]) & CTRL_MASK[k]) == '0) m = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/iw_parcel_ring.sv
// Parcel ring: circular storage of DEPTH parcels with head/tail pointers
// and an occupancy count. Presents the contents rotated so that view_o[0]
// is the head parcel. Assumes the caller never pushes without room and
// never retires more parcels than are held. Flush overrides push and retire.
module iw_parcel_ring
    import iw_pkg::*;
#(
    parameter int DEPTH  = 12,
    parameter int WORD_P = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int RET_W = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush_i,
    input  logic                         push_i,
    input  logic [WORD_P*PARCEL_W-1:0]   word_i,
    input  logic [RET_W-1:0]             retire_i,
    output logic [CNT_W-1:0]             count_o,
    output parcel_t [DEPTH-1:0]          view_o
);
    logic [PTR_W-1:0] rd_q, wr_q;
    logic [CNT_W-1:0] cnt_q;
    parcel_t          mem_q [DEPTH];
    logic [PTR_W-1:0] wr_idx [WORD_P];

    // Modular pointer advance for a non-power-of-two depth.
    function automatic logic [PTR_W-1:0] wrap(logic [PTR_W-1:0] p, int unsigned n);
        int unsigned s;
        s = 32'(p) + n;
        if (s >= DEPTH) s = s - DEPTH;
        return PTR_W'(s);
    endfunction

    // Rotate storage so that the head parcel appears at index 0.
    for (genvar i = 0; i < DEPTH; i++) begin : g_view
        assign view_o[i] = mem_q[wrap(rd_q, i)];
    end

    // Storage slot that each parcel of an incoming word lands in.
    for (genvar k = 0; k < WORD_P; k++) begin : g_widx
        assign wr_idx[k] = wrap(wr_q, k);
    end

    // Pointer, count and storage update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (flush_i) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_i) begin
                for (int k = 0; k < WORD_P; k++) begin
                    mem_q[wr_idx[k]] <= word_i[k*PARCEL_W +: PARCEL_W];
                end
                wr_q <= wrap(wr_q, WORD_P);
            end
            rd_q  <= wrap(rd_q, 32'(retire_i));
            cnt_q <= cnt_q - CNT_W'(retire_i) + (push_i ? CNT_W'(WORD_P) : '0);
        end
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/iw_head_extract.sv
// Head extract: from the first four parcels and the count, forms the two
// issue slots and the number of parcels to retire for the requested take.
// Assumes count_i never exceeds the ring depth.
module iw_head_extract
    import iw_pkg::*;
#(
    parameter int DEPTH  = 12,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int INS_W = 2 * PARCEL_W
) (
    input  parcel_t [3:0]     head_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [1:0]        take_i,
    output logic              s0_valid_o,
    output logic              s0_long_o,
    output logic [INS_W-1:0]  s0_instr_o,
    output logic              s1_valid_o,
    output logic              s1_long_o,
    output logic [INS_W-1:0]  s1_instr_o,
    output logic [2:0]        retire_o
);
    int      cnt, off1, want, have, n_take;
    parcel_t first1, second1;

    // Slot decode and retire count.
    always_comb begin
        cnt        = int'(count_i);
        s0_long_o  = head_i[0][0];
        s0_valid_o = (cnt >= 1) && (!s0_long_o || cnt >= 2);
        s0_instr_o = s0_long_o ? {head_i[1], head_i[0]} : {{PARCEL_W{1'b0}}, head_i[0]};

        off1       = s0_long_o ? 2 : 1;
        first1     = s0_long_o ? head_i[2] : head_i[1];
        second1    = s0_long_o ? head_i[3] : head_i[2];
        s1_long_o  = first1[0];
        s1_valid_o = s0_valid_o && (cnt > off1) && (!s1_long_o || cnt >= off1 + 2);
        s1_instr_o = s1_long_o ? {second1, first1} : {{PARCEL_W{1'b0}}, first1};

        want   = (take_i == 2'd0) ? 0 : (take_i == 2'd1) ? 1 : 2;
        have   = int'(s0_valid_o) + int'(s1_valid_o);
        n_take = (want < have) ? want : have;
        retire_o = 3'((n_take >= 1) ? (s0_long_o ? 2 : 1) : 0)
                 + 3'((n_take >= 2) ? (s1_long_o ? 2 : 1) : 0);
    end
endmodule

// File: rtl/iw_branch_scan.sv
// Branch scan: walks instruction boundaries from the head across the whole
// window and flags any complete instruction whose first parcel matches the
// control-flow table. Assumes view_i[0] is the head parcel.
module iw_branch_scan
    import iw_pkg::*;
#(
    parameter int DEPTH  = 12,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  parcel_t [DEPTH-1:0] view_i,
    input  logic [CNT_W-1:0]    count_i,
    output logic                has_branch_o
);
    logic sp1, lp1, sp2, lp2, cur, whole;

    // Serial boundary walk with the two previous positions carried along.
    always_comb begin
        sp1 = 1'b0; lp1 = 1'b0; sp2 = 1'b0; lp2 = 1'b0;
        cur = 1'b0; whole = 1'b0;
        has_branch_o = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            cur   = (i == 0) ? 1'b1 : ((sp1 && !lp1) || (sp2 && lp2));
            whole = cur && (i < int'(count_i))
                    && (!view_i[i][0] || (i + 1 < int'(count_i)));
            if (whole && is_ctrl(view_i[i])) has_branch_o = 1'b1;
            sp2 = sp1;
            lp2 = lp1;
            sp1 = cur;
            lp1 = view_i[i][0];
        end
    end
endmodule

// File: rtl/instr_window.sv
// Instruction window top: joins the parcel ring, the head extractor and the
// branch scan, and derives the fetch-side flags. Assumes take_i never asks
// for more than the issue logic can use; excess requests are clamped.
module instr_window
    import iw_pkg::*;
#(
    parameter int DEPTH  = 12,
    parameter int WORD_P = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int FW    = WORD_P * PARCEL_W,
    localparam int INS_W = 2 * PARCEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              fetch_valid_i,
    input  logic [FW-1:0]     fetch_word_i,
    input  logic [1:0]        take_i,
    output logic              slot0_valid_o,
    output logic              slot0_long_o,
    output logic [INS_W-1:0]  slot0_instr_o,
    output logic              slot1_valid_o,
    output logic              slot1_long_o,
    output logic [INS_W-1:0]  slot1_instr_o,
    output logic [CNT_W-1:0]  level_o,
    output logic              full_o,
    output logic              refill_req_o,
    output logic              has_branch_o
);
    logic [CNT_W-1:0]    count;
    parcel_t [DEPTH-1:0] view;
    logic [2:0]          retire;
    logic                push;

    // Fetch-side flags: room for a word now, and after this cycle's retirement.
    always_comb begin
        full_o       = (DEPTH - int'(count)) < WORD_P;
        refill_req_o = (DEPTH - (int'(count) - int'(retire))) >= WORD_P;
        push         = fetch_valid_i && !full_o && !flush_i;
    end

    iw_parcel_ring #(.DEPTH(DEPTH), .WORD_P(WORD_P)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush_i  (flush_i),
        .push_i   (push),
        .word_i   (fetch_word_i),
        .retire_i (retire),
        .count_o  (count),
        .view_o   (view)
    );

    iw_head_extract #(.DEPTH(DEPTH)) u_head (
        .head_i     (view[3:0]),
        .count_i    (count),
        .take_i     (take_i),
        .s0_valid_o (slot0_valid_o),
        .s0_long_o  (slot0_long_o),
        .s0_instr_o (slot0_instr_o),
        .s1_valid_o (slot1_valid_o),
        .s1_long_o  (slot1_long_o),
        .s1_instr_o (slot1_instr_o),
        .retire_o   (retire)
    );

    iw_branch_scan #(.DEPTH(DEPTH)) u_scan (
        .view_i       (view),
        .count_i      (count),
        .has_branch_o (has_branch_o)
    );

    assign level_o = count;
endmodule

// File: rtl/iw_window_checks.sv
// Checker: temporal properties of the instruction window, bound to the top.
module iw_window_checks #(
    parameter int DEPTH  = 12,
    parameter int WORD_P = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush_i,
    input logic             fetch_valid_i,
    input logic [1:0]       take_i,
    input logic             slot0_valid_o,
    input logic             slot0_long_o,
    input logic             slot1_valid_o,
    input logic [CNT_W-1:0] level_o,
    input logic             full_o,
    input logic             refill_req_o
);
    AST_LONG_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        slot0_valid_o && slot0_long_o |-> int'(level_o) >= 2); // R3
    AST_SLOT1_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        slot1_valid_o |-> slot0_valid_o); // R4
    AST_PUSH_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_i && fetch_valid_i && !full_o && take_i == 2'd0
        |=> int'(level_o) == int'($past(level_o)) + WORD_P); // R6
    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid_i && full_o && !flush_i |=> level_o <= $past(level_o)); // R7
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(level_o) <= DEPTH); // R7
    AST_ROOM_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        !full_o |-> refill_req_o); // R8
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> level_o == '0 && !slot0_valid_o); // R9
endmodule

bind instr_window iw_window_checks #(.DEPTH(DEPTH), .WORD_P(WORD_P)) u_checks (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush_i       (flush_i),
    .fetch_valid_i (fetch_valid_i),
    .take_i        (take_i),
    .slot0_valid_o (slot0_valid_o),
    .slot0_long_o  (slot0_long_o),
    .slot1_valid_o (slot1_valid_o),
    .level_o       (level_o),
    .full_o        (full_o),
    .refill_req_o  (refill_req_o)
);

// File: tb/instr_window_tb_top.sv
`timescale 1ns/1ps
module instr_window_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        fvalid = 1'b0;
    logic [63:0] fword = '0;
    logic [1:0]  take = '0;
    logic        s0v, s0l, s1v, s1l, full, refill, hasbr;
    logic [31:0] s0i, s1i;
    logic [3:0]  level;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;
    logic [15:0] mq[$];

    always #2.5 clk = ~clk;

    instr_window dut_i (
        .clk(clk), .rst_n(rst_n), .flush_i(flush), .fetch_valid_i(fvalid),
        .fetch_word_i(fword), .take_i(take),
        .slot0_valid_o(s0v), .slot0_long_o(s0l), .slot0_instr_o(s0i),
        .slot1_valid_o(s1v), .slot1_long_o(s1l), .slot1_instr_o(s1i),
        .level_o(level), .full_o(full), .refill_req_o(refill), .has_branch_o(hasbr)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit ctrl_byte(logic [7:0] b);
        return b == 8'h3C || b == 8'h5E || b == 8'h1D || b == 8'h6D;
    endfunction

    // Branch expectation from a length walk over the model queue (R10).
    function automatic bit exp_branch();
        int i = 0;
        bit br = 0;
        while (i < mq.size()) begin
            if (mq[i][0] && i + 1 >= mq.size()) break;
            if (ctrl_byte(mq[i][7:0])) br = 1;
            i += mq[i][0] ? 2 : 1;
        end
        return br;
    endfunction

    // One cycle: drive, compare all outputs against the model, update model.
    task automatic step(input logic fl, input logic fv, input logic [63:0] w, input logic [1:0] tk);
        int n, o, want, nt, ret;
        bit e0v, e0l, e1v, e1l, efull;
        logic [31:0] e0i, e1i;
        @(negedge clk);
        flush = fl; fvalid = fv; fword = w; take = tk;
        #1;
        n = mq.size();
        e0v = 0; e0l = 0; e1v = 0; e1l = 0; e0i = '0; e1i = '0;
        if (n >= 1) begin
            e0l = mq[0][0];
            if (!e0l) begin e0v = 1; e0i = {16'h0, mq[0]}; end
            else if (n >= 2) begin e0v = 1; e0i = {mq[1], mq[0]}; end
        end
        o = e0l ? 2 : 1;
        if (e0v && n > o) begin
            e1l = mq[o][0];
            if (!e1l) begin e1v = 1; e1i = {16'h0, mq[o]}; end
            else if (n >= o + 2) begin e1v = 1; e1i = {mq[o+1], mq[o]}; end
        end
        want = (tk > 2) ? 2 : int'(tk);
        nt = (want < int'(e0v) + int'(e1v)) ? want : int'(e0v) + int'(e1v);
        ret = (nt >= 1 ? (e0l ? 2 : 1) : 0) + (nt >= 2 ? (e1l ? 2 : 1) : 0);
        efull = (12 - n) < 4;
        chk("R11 level", 64'(level), 64'(n));
        chk("R2 R3 slot0 valid", 64'(s0v), 64'(e0v));
        if (e0v) chk("R2 slot0 data", {31'h0, s0l, s0i}, {31'h0, e0l, e0i});
        chk("R4 slot1 valid", 64'(s1v), 64'(e1v));
        if (e1v) chk("R4 slot1 data", {31'h0, s1l, s1i}, {31'h0, e1l, e1i});
        chk("R7 full", 64'(full), 64'(efull));
        chk("R8 refill", 64'(refill), 64'((12 - (n - ret)) >= 4));
        chk("R10 has_branch", 64'(hasbr), 64'(exp_branch()));
        @(posedge clk);
        if (fl) mq.delete();
        else begin
            for (int k = 0; k < ret; k++) void'(mq.pop_front());
            if (fv && !efull)
                for (int k = 0; k < 4; k++) mq.push_back(w[k*16 +: 16]);
        end
    endtask

    task automatic idle_look();
        @(negedge clk);
        flush = 0; fvalid = 0; take = 0;
        #1;
    endtask

    function automatic logic [15:0] rnd_parcel();
        logic [15:0] p = 16'($urandom);
        if ($urandom_range(3) == 0) begin
            case ($urandom_range(3))
                0: p[7:0] = 8'h3C;
                1: p[7:0] = 8'h5E;
                2: p[7:0] = 8'h1D;
                default: p[7:0] = 8'h6D;
            endcase
        end
        return p;
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'hC0DE_5EED));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        idle_look();
        // R1 reset state
        chk("R1 level", 64'(level), 0);
        chk("R1 valids", {s0v, s1v, full, hasbr}, 0);
        chk("R1 refill", 64'(refill), 1);

        // R3 straddling long: three shorts then a lone long first parcel
        step(0, 1, {16'h1001, 16'h0400, 16'h0200, 16'h0100}, 0);
        step(0, 0, '0, 2);
        step(0, 0, '0, 1);
        idle_look();
        chk("R3 lone first parcel invalid", 64'(s0v), 0);
        step(0, 1, {16'h0008, 16'h0006, 16'h0004, 16'hBEEF}, 0);
        idle_look();
        chk("R3 completed long", {s0v, s0l, s0i}, {1'b1, 1'b1, 32'hBEEF_1001});
        chk("R4 slot1 after long", {s1v, s1i}, {1'b1, 32'h0000_0004});

        // R7 fill to twelve parcels, extra word dropped
        step(1, 0, '0, 0);
        for (int k = 0; k < 4; k++) step(0, 1, {4{16'h0010 + 16'(k)}}, 0);
        idle_look();
        chk("R7 full level", {full, level}, {1'b1, 4'd12});
        // R5 take=3 acts as 2
        step(0, 0, '0, 3);
        idle_look();
        chk("R5 clamp take3", 64'(level), 10);

        // R9 flush beats fetch and take
        step(1, 1, 64'h1111_2222_3333_4444, 2);
        idle_look();
        chk("R9 flush empties", {level, s0v}, 0);

        // R10 trailing incomplete control-flow long does not count
        step(0, 1, {16'h001D, 16'h0400, 16'h0200, 16'h0100}, 0);
        idle_look();
        chk("R10 incomplete ctrl", 64'(hasbr), 0);
        step(0, 1, {16'h0002, 16'h0002, 16'h0002, 16'h0000}, 0);
        idle_look();
        chk("R10 complete ctrl", 64'(hasbr), 1);
        step(1, 0, '0, 0);

        // Random mix of fetch, take and flush (R5 R6 R11 coincidences)
        for (int c = 0; c < 4000; c++) begin
            logic [63:0] w = {rnd_parcel(), rnd_parcel(), rnd_parcel(), rnd_parcel()};
            step($urandom_range(40) == 0, $urandom_range(9) < 7, w, 2'($urandom_range(3)));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule